// File: doc/BRIEF.md
# Phased Bus Enable and Peripheral Strobe Generator

This block divides each processor bus cycle into two halves and hands the shared address and data bus to one owner at a time. It runs from a fast dot clock and derives the processor clock (PHI2) by dividing it. The processor's bus enable is high while PHI2 is high. A second bus master, typically a video fetch engine, is granted the bus while PHI2 is low.

A 65xx-style peripheral latches its address and read/write inputs on the rising edge of its own clock, so those inputs must already be stable at that edge. The block gives it a shortened clock that is high only in the final quarter of each processor cycle. The block also gives it a chip select that is passed only while PHI2 is high, so an address presented during the video half never selects it.

A wide mode serves a 16-bit processor variant. That processor places its bank byte on the data bus during the low half of the cycle. When its valid-data or valid-program flag is set in that half, the bus stays with the processor and the video master is held off.

Top module: `bus_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, `phi2`, `periph_clk`, `cpu_be`, `video_grant` and `periph_cs` are all 0. The first dot clock period after `rst_n` is released is phase 0 of a processor cycle.
- R2: A processor cycle lasts DIV dot clock periods (8 by default), numbered 0 to DIV-1. `phi2` is low in phases 0 to DIV/2-1 and high in phases DIV/2 to DIV-1. Both phase outputs come from registers.
- R3: `periph_clk` is high only in the final DIV/4 phases of the cycle (phases 6 and 7 by default). It is therefore never high while `phi2` is low.
- R4: `cpu_be` is 1 in every phase in which `phi2` is 1.
- R5: With `wide_mode` at 0, `cpu_be` is 0 and `video_grant` is 1 throughout every `phi2`-low phase, whatever the values of `cpu_vda` and `cpu_vpa`.
- R6: With `wide_mode` at 1, a `phi2`-low phase in which `cpu_vda` or `cpu_vpa` is 1 has `cpu_be` at 1 and `video_grant` at 0, within the same dot period.
- R7: With `wide_mode` at 1 and both `cpu_vda` and `cpu_vpa` at 0, a `phi2`-low phase has `video_grant` at 1 and `cpu_be` at 0.
- R8: `cpu_be` and `video_grant` are never both 1. `video_grant` is never 1 while `phi2` is 1.
- R9: `periph_cs` equals `io_hit` while `phi2` is 1. It is 0 while `phi2` is 0, whatever the value of `io_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, DIV times the processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 selects the 16-bit processor rule for holding the bus in the low phase |
| cpu_vda | input | 1 | Processor flag: valid data address |
| cpu_vpa | input | 1 | Processor flag: valid program address |
| io_hit | input | 1 | Address decode hit for the peripheral |
| phi2 | output | 1 | Processor clock, high in the second half of the cycle |
| periph_clk | output | 1 | Peripheral clock, high in the last quarter of the cycle |
| cpu_be | output | 1 | Processor bus enable |
| video_grant | output | 1 | Bus grant to the second master |
| periph_cs | output | 1 | Active-high peripheral chip select, qualified by PHI2 |

## Verification
A wrong value in the phase counter shows at the ports within one dot period: `phi2` or `periph_clk` switches at the wrong phase, and every processor cycle after that is shifted. A bad arbitration term shows in the same dot period in which it occurs. Either both enables are high, or the video grant appears while a wide-mode processor flags a valid address. The scoreboard compares all five outputs in every dot period, so a fault is reported in the cycle in which it first becomes visible.

// File: rtl/bph_pkg.sv
// Package: types shared by the phased bus controller.
// Assumes: nothing; holds only type definitions.
package bph_pkg;
    // Registered phase outputs of the divider
    typedef struct packed {
        logic hi_half;   // processor clock level
        logic last_qtr;  // peripheral clock level
    } phase_t;
endpackage

// File: rtl/bph_phase_gen.sv
// Module: divides the dot clock into processor cycles of 2**CW phases and
// produces registered, glitch-free PHI2 and peripheral clock levels.
// Assumes: CW >= 2; synchronous active-low reset returns to phase 0.
module bph_phase_gen
    import bph_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    localparam int             DIV   = 1 << CW;
    localparam logic [CW-1:0]  HALF  = CW'(DIV / 2);
    localparam logic [CW-1:0]  LASTQ = CW'(DIV - DIV / 4);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          hi_q;
    logic          lq_q;

    // next phase index, wrapping at DIV
    always_comb cnt_nx = cnt_q + 1'b1;

    // phase counter and registered level decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
            lq_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            hi_q  <= (cnt_nx >= HALF);
            lq_q  <= (cnt_nx >= LASTQ);
        end
    end

    assign phase.hi_half  = hi_q;
    assign phase.last_qtr = lq_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));

    assert_phi2_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (cnt_q == HALF));

    assert_pclk_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lq_q |-> hi_q);

    assert_pclk_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lq_q) |-> $past(hi_q));
endmodule

// File: rtl/bph_bus_arbiter.sv
// Module: decides which master owns the shared bus in the current dot period.
// Assumes: phi2 comes from a register; vda/vpa are valid for the whole low
// half. Outputs are forced low while rst_n is low.
module bph_bus_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic wide_mode,
    input  logic cpu_vda,
    input  logic cpu_vpa,
    output logic cpu_be,
    output logic video_grant
);
    logic hold_low;

    // wide processor keeps the bus when it flags a valid address
    always_comb hold_low = wide_mode & (cpu_vda | cpu_vpa);

    // ownership decision for this dot period
    always_comb begin
        cpu_be      = rst_n & (phi2 | hold_low);
        video_grant = rst_n & ~phi2 & ~hold_low;
    end

    assert_owner_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_be && video_grant));

    assert_no_grant_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |-> !video_grant);

    assert_cpu_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |-> cpu_be);

    assert_wide_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && (cpu_vda || cpu_vpa)) |-> (cpu_be && !video_grant));
endmodule

// File: rtl/bph_periph_sel.sv
// Module: chip select for the 65xx-style peripheral, passed only in PHI2 high.
// Assumes: io_hit is a plain address decode with no phase knowledge.
module bph_periph_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic io_hit,
    output logic periph_cs
);
    // qualify the decode with the processor half of the cycle
    always_comb periph_cs = rst_n & phi2 & io_hit;

    assert_cs_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
        periph_cs |-> phi2);
endmodule

// File: rtl/bus_phase_ctrl.sv
// Module: top of the phased bus controller. Divides the dot clock into
// processor cycles, arbitrates the shared bus per half cycle and times the
// peripheral clock and select.
// Assumes: dot clock is 2**CW times the processor clock; synchronous reset.
module bus_phase_ctrl
    import bph_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wide_mode,
    input  logic cpu_vda,
    input  logic cpu_vpa,
    input  logic io_hit,
    output logic phi2,
    output logic periph_clk,
    output logic cpu_be,
    output logic video_grant,
    output logic periph_cs
);
    phase_t ph;

    bph_phase_gen #(.CW(CW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (ph)
    );

    assign phi2       = ph.hi_half;
    assign periph_clk = ph.last_qtr;

    bph_bus_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .phi2        (ph.hi_half),
        .wide_mode   (wide_mode),
        .cpu_vda     (cpu_vda),
        .cpu_vpa     (cpu_vpa),
        .cpu_be      (cpu_be),
        .video_grant (video_grant)
    );

    bph_periph_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (ph.hi_half),
        .io_hit    (io_hit),
        .periph_cs (periph_cs)
    );
endmodule

// File: tb/test_bus_phase_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver pushes the expected outputs for each dot
// period; the monitor pops them and compares them away from the clock edge.
module test_bus_phase_ctrl;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wide_mode = 1'b0, cpu_vda = 1'b0, cpu_vpa = 1'b0, io_hit = 1'b0;
    logic phi2, periph_clk, cpu_be, video_grant, periph_cs;

    int total = 0;
    int bad = 0;
    int k = 0;
    bit done = 1'b0;

    typedef struct {
        logic phi2, pclk, be, grant, cs;
        bit   rst;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bus_phase_ctrl i_bus_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cpu_vda(cpu_vda),
        .cpu_vpa(cpu_vpa), .io_hit(io_hit), .phi2(phi2), .periph_clk(periph_clk),
        .cpu_be(cpu_be), .video_grant(video_grant), .periph_cs(periph_cs)
    );

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s phase=%0d actual=%b expected=%b", req, k % DIV, act, exp);
        end
    endtask

    // driver: apply inputs at the falling edge and push the expected outputs
    task automatic step(input bit r, input bit w, input bit vda, input bit vpa, input bit hit);
        exp_t e;
        bit hold;
        @(negedge clk);
        rst_n = r; wide_mode = w; cpu_vda = vda; cpu_vpa = vpa; io_hit = hit;
        hold = w & (vda | vpa);
        e.rst = !r;
        if (!r) begin
            e.phi2 = 0; e.pclk = 0; e.be = 0; e.grant = 0; e.cs = 0;
        end else begin
            e.phi2  = (k % DIV) >= DIV / 2;
            e.pclk  = (k % DIV) >= DIV - DIV / 4;
            e.be    = e.phi2 | hold;
            e.grant = !e.phi2 & !hold;
            e.cs    = e.phi2 & hit;
        end
        sb.push_back(e);
        @(posedge clk);
        k = r ? k + 1 : 0;
    endtask

    // monitor: compare every output one ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.rst) begin
                check(phi2 === 0 && periph_clk === 0 && periph_cs === 0, "R1 phase/cs in reset",
                      phi2 | periph_clk | periph_cs, 1'b0);
                check(cpu_be === 0 && video_grant === 0, "R1 enables in reset",
                      cpu_be | video_grant, 1'b0);
            end else begin
                check(phi2 === e.phi2, "R2 phi2", phi2, e.phi2);
                check(periph_clk === e.pclk, "R3 periph_clk", periph_clk, e.pclk);
                check(cpu_be === e.be, e.phi2 ? "R4 cpu_be" : "R5/R6 cpu_be", cpu_be, e.be);
                check(video_grant === e.grant, e.phi2 ? "R8 video_grant" : "R5/R7 video_grant",
                      video_grant, e.grant);
                check(periph_cs === e.cs, "R9 periph_cs", periph_cs, e.cs);
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(0, 1, 1, 1, 1);
        // R2 R3 R5 R9: narrow mode, VDA/VPA toggling must not matter
        for (int i = 0; i < 4 * DIV; i++)
            step(1, 0, 1'($urandom), 1'($urandom), 1'($urandom));
        // R6 R7: wide mode with random flags
        for (int i = 0; i < 4 * DIV; i++)
            step(1, 1, 1'($urandom), 1'($urandom), 1'($urandom));
        // R6: wide mode, flags held high, video master kept off
        for (int i = 0; i < 2 * DIV; i++)
            step(1, 1, 1'(i % 2), 1'((i / 2) % 2) | 1'(~(i % 2)), 1'b1);
        // R7: wide mode, flags low
        for (int i = 0; i < 2 * DIV; i++)
            step(1, 1, 0, 0, 1'(i % 2));
        // R1: reset in mid cycle, then phase restarts at 0
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1);
        repeat (2) step(0, 0, 0, 0, 1);
        for (int i = 0; i < 2 * DIV; i++)
            step(1, 0, 1'($urandom), 1'($urandom), 1'b1);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule